// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Trigger

This block decides when a quasi-resonant flyback switch turns on again. Once the gate driver turns off, the block waits out a fixed blanking window so that the leakage-inductance ringing cannot be mistaken for resonance. It then counts valleys of the auxiliary-winding voltage. A valley is a falling edge of the zero-crossing comparator. When the count reaches the valley number chosen by the load-dependent selection logic, the block emits a one-cycle set pulse. That pulse starts the next on-time.

Heavily damped ringing can leave a valley too shallow for the comparator to see. A retriggered timeout covers that case. If no valley arrives within the timeout window, the block inserts a synthetic valley and starts the window again. Several missing valleys in a row each add one count, so the switch still turns on close to the intended valley instead of stalling. The valley selection is captured only at the moment the driver turns off, so a selection that changes during an off-time never disturbs a count already running. Durations are parameters in clock cycles.

Top module: `qr_valley_trigger`

## Requirements
- R1: After reset, and in any cycle that follows a clock edge at which `drv_on` was high, `set_pulse` is low.
- R2: A high-to-low transition of `zcd_cmp` counts as one valley. The input passes a `SYNC_STAGES`-deep synchronizer, so with the default of 2, a fall first sampled at edge f is counted at edge f+2.
- R3: During the `BLANK_CYC` clock edges that follow the edge at which `drv_on` is first sampled low, comparator falls are ignored. A fall whose count edge would be the `BLANK_CYC`-th edge after turn-off is also ignored.
- R4: Once blanking ends, if `TIMEOUT_CYC` edges pass with no counted valley, one synthetic valley is counted.
- R5: The timeout restarts after every counted valley, real or synthetic, so consecutive missing valleys each add one count.
- R6: `valley_sel` encodes the target valley as 0 = 1st, 1 = 2nd, 2 = 3rd, 3 = 4th. `set_pulse` goes high for exactly one cycle, at the edge that counts the selected valley.
- R7: At most one `set_pulse` is issued per off-time. Falls or timeouts after that pulse have no effect until the driver cycles.
- R8: While `drv_on` is high the valley count is cleared, so an off-time cut short by a turn-on leaves nothing behind for the next off-time.
- R9: `valley_sel` is sampled only at the edge where the driver turn-off is first seen. Changes later in the off-time have no effect on that off-time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_on | input | 1 | Gate driver state, high during the on-time |
| zcd_cmp | input | 1 | Zero-crossing comparator output, asynchronous, low when the auxiliary winding is below threshold |
| valley_sel | input | VSEL_W | Target valley, 0-based |
| set_pulse | output | 1 | One-cycle request to start the next on-time |

## Verification
The bench builds the block with `BLANK_CYC` = 6 and `TIMEOUT_CYC` = 10, and keeps the two-stage synchronizer. These short values make every expected latency a small whole number of edges. The 4th-valley case made entirely of synthetic valleys ends after 47 edges. With these values, one off-time can combine real falls, falls exactly at the blanking edge, and chains of retriggered timeouts. The same small windows let a turn-on abort a count partway through, so the cleared count can be checked in the very next off-time.

// File: rtl/qr_valley_pkg.sv
package qr_valley_pkg;

  // Off-time sequencing: idle (driver on), blanking, valley hunting, done.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_HUNT  = 2'd2,
    ST_DONE  = 2'd3
  } trig_state_e;

endpackage

// File: rtl/qr_zcd_edge.sv
module qr_zcd_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_in,
  output logic fall_evt
);

  // pipe_q[STAGES-1] is the synchronized level; pipe_q[STAGES] holds it one cycle older.
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], cmp_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign fall_evt = pipe_q[STAGES] & ~pipe_q[STAGES-1];

endmodule

// File: rtl/qr_cycle_timer.sv
module qr_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic hit
);

  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign hit = (cnt_q == LAST);

  always_comb begin
    cnt_en = restart | (run & ~hit);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: the window counter never runs past its terminal value
  assert_timer_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/qr_valley_tally.sv
module qr_valley_tally #(
  parameter int VSEL_W = 2,
  parameter int CNT_W  = VSEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inc,
  input  logic [VSEL_W-1:0] target,
  output logic              reach,
  output logic [CNT_W-1:0]  count
);

  localparam int MAXV = 1 << VSEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // target is 0-based, so the selected valley is counted when cnt_q equals it.
  assign reach = inc & (cnt_q == CNT_W'(target));
  assign count = cnt_q;

  always_comb begin
    cnt_en = clear | inc;
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: the tally never goes beyond the deepest selectable valley
  assert_tally_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAXV));

endmodule

// File: rtl/qr_valley_trigger.sv
module qr_valley_trigger
  import qr_valley_pkg::*;
#(
  parameter int BLANK_CYC   = 300,
  parameter int TIMEOUT_CYC = 525,
  parameter int SYNC_STAGES = 2,
  parameter int VSEL_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv_on,
  input  logic              zcd_cmp,
  input  logic [VSEL_W-1:0] valley_sel,
  output logic              set_pulse
);

  localparam int CNT_W = VSEL_W + 1;

  trig_state_e       st_q, st_d;
  logic              drv_q;
  logic [VSEL_W-1:0] sel_q;
  logic              set_q, set_d;

  logic              off_start;
  logic              fall_evt;
  logic              blank_hit;
  logic              tmo_hit;
  logic              hunting;
  logic              valley_evt;
  logic              tally_inc;
  logic              tally_reach;
  logic [CNT_W-1:0]  tally;

  assign off_start  = drv_q & ~drv_on;
  assign hunting    = (st_q == ST_HUNT) & ~drv_on;
  assign valley_evt = hunting & (fall_evt | tmo_hit);
  assign tally_inc  = valley_evt;

  qr_zcd_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_in   (zcd_cmp),
    .fall_evt (fall_evt)
  );

  qr_cycle_timer #(.LIMIT(BLANK_CYC)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (off_start),
    .run     (st_q == ST_BLANK),
    .hit     (blank_hit)
  );

  qr_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (~hunting | valley_evt),
    .run     (hunting),
    .hit     (tmo_hit)
  );

  qr_valley_tally #(.VSEL_W(VSEL_W), .CNT_W(CNT_W)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (drv_on | off_start),
    .inc    (tally_inc),
    .target (sel_q),
    .reach  (tally_reach),
    .count  (tally)
  );

  always_comb begin
    st_d  = st_q;
    set_d = 1'b0;
    if (drv_on) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (off_start) st_d = ST_BLANK;
        ST_BLANK: if (blank_hit) st_d = ST_HUNT;
        ST_HUNT:  if (tally_reach) begin
                    st_d  = ST_DONE;
                    set_d = 1'b1;
                  end
        ST_DONE:  st_d = ST_DONE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      drv_q <= 1'b0;
      set_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      drv_q <= drv_on;
      set_q <= set_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= '0;
    else if (off_start) sel_q <= valley_sel;
  end

  assign set_pulse = set_q;

  // R6: the turn-on request lasts a single cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_q |=> !set_q);

  // R1: no request after an edge that saw the driver on
  assert_quiet_when_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> !set_q);

  // R3: nothing is counted while blanking
  assert_blank_holds_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLANK) |=> (tally == '0));

  // R7: once done, the state holds until the driver turns on
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && !drv_on) |=> (st_q == ST_DONE && !set_q));

endmodule

// File: tb/qr_valley_trigger_bench.sv
module qr_valley_trigger_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 6;
  localparam int TMO        = 10;
  localparam int WINDOW     = 90;
  localparam int NV         = 9;

  // columns: sel, fall1, fall2, fall3, fall4 (0 = none), expected latency in edges
  localparam int VEC [NV][6] = '{
    '{0, 9,  0,  0,  0, 11},  // R2 single real valley
    '{1, 9, 14,  0,  0, 16},  // R2 two real valleys
    '{3, 9, 12, 15, 18, 20},  // R2 R6 four real valleys
    '{0, 3,  0,  0,  0, 17},  // R3 fall deep in blanking
    '{0, 5,  0,  0,  0, 17},  // R3 fall counted on last blanking edge
    '{0, 6,  0,  0,  0,  8},  // R3 first edge after blanking
    '{2, 9,  0,  0,  0, 31},  // R5 real then two synthetic
    '{3, 0,  0,  0,  0, 47},  // R4 R5 four synthetic
    '{1, 9,  0,  0,  0, 21}   // R4 real then synthetic
  };

  logic       clk;
  logic       rst_n;
  logic       drv_on;
  logic       zcd_cmp;
  logic [1:0] valley_sel;
  logic       set_pulse;

  int total;
  int bad;
  int cycles;

  qr_valley_trigger #(
    .BLANK_CYC   (BLANK),
    .TIMEOUT_CYC (TMO),
    .SYNC_STAGES (2),
    .VSEL_W      (2)
  ) u_qr_valley_trigger (
    .clk        (clk),
    .rst_n      (rst_n),
    .drv_on     (drv_on),
    .zcd_cmp    (zcd_cmp),
    .valley_sel (valley_sel),
    .set_pulse  (set_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One off-time starting at a falling clock edge; the first rising edge is edge 1.
  task automatic off_time(input int sel, input int f1, input int f2, input int f3,
                          input int f4, input int late_sel, input int abort_at,
                          output int lat, output int npulse, output int on_pulse);
    lat = 0; npulse = 0; on_pulse = 0;
    valley_sel = 2'(sel);
    drv_on     = 1'b0;
    for (int e = 1; e <= WINDOW; e++) begin
      logic low;
      low = 1'b0;
      if (f1 != 0 && (e == f1 || e == f1 + 1)) low = 1'b1;
      if (f2 != 0 && (e == f2 || e == f2 + 1)) low = 1'b1;
      if (f3 != 0 && (e == f3 || e == f3 + 1)) low = 1'b1;
      if (f4 != 0 && (e == f4 || e == f4 + 1)) low = 1'b1;
      zcd_cmp = ~low;
      if (late_sel >= 0 && e == 3) valley_sel = 2'(late_sel);
      if (abort_at > 0 && e == abort_at) drv_on = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (set_pulse) begin
        npulse++;
        if (lat == 0) lat = e;
        if (drv_on) on_pulse++;
      end
    end
    zcd_cmp = 1'b1;
    drv_on  = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int lat, np, onp;
    total = 0; bad = 0;
    rst_n = 1'b0; drv_on = 1'b1; zcd_cmp = 1'b1; valley_sel = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 reset", int'(set_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: driver held on with comparator activity gives no pulse
    np = 0;
    for (int i = 0; i < 20; i++) begin
      zcd_cmp = i[1];
      @(negedge clk);
      if (set_pulse) np++;
    end
    zcd_cmp = 1'b1;
    check("R1 driver on", np, 0);
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      off_time(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], -1, 0, lat, np, onp);
      check($sformatf("R2/R3/R4/R5/R6 latency vec%0d", v), lat, VEC[v][5]);
      check($sformatf("R6/R7 pulse count vec%0d", v), np, 1);
    end

    // R9: selection change after turn-off is ignored (captured 1st valley)
    off_time(0, 0, 0, 0, 0, 3, 0, lat, np, onp);
    check("R9 late selection", lat, 17);

    // R8: off-time aborted after two synthetic valleys, then a fresh 4th-valley run
    off_time(3, 0, 0, 0, 0, -1, 30, lat, np, onp);
    check("R8 aborted off-time pulses", np, 0);
    check("R1 pulses while on", onp, 0);
    off_time(3, 0, 0, 0, 0, -1, 0, lat, np, onp);
    check("R8 fresh count latency", lat, 47);

    // R7: extra real falls after the pulse are ignored
    off_time(0, 9, 20, 30, 40, -1, 0, lat, np, onp);
    check("R7 falls after pulse", np, 1);
    check("R2 first valley latency", lat, 11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule